// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit turns decoded addressing-mode fields into a 32-bit memory offset. For each request it takes a mode code, a base value, an index value, a two-bit scale code, a displacement with a width flag and an access size. It returns the wrapped 32-bit sum of the terms that the mode selects. It also reports whether that offset is misaligned for the requested access size. Misaligned accesses are legal, so the flag is only information for later stages.

The result leaves through one registered stage with a valid/ready handshake. An accepted request appears on the outputs on the next clock edge. While the consumer holds ready low, the stage keeps its result steady and takes no new request. Segment translation, protection, register-file reads and instruction decoding take place outside this unit.

Top module: `agu_offset_gen`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Mode codes select the terms that are added: 0 = displacement only (absolute), 1 = base, 2 = base + displacement, 3 = base + index, 4 = base + index + displacement, 5 = base + scaled index, 6 = base + scaled index + displacement. A term that the mode does not name has no effect on the result.
- R3: Scale codes 00, 01, 10 and 11 multiply the index by 1, 2, 4 and 8. The scale code applies only in modes 5, 6 and 7. In modes 3 and 4 the index is added unscaled.
- R4: When `in_disp_wide` is 1, all 32 bits of `in_disp` are used. When it is 0, only bits 7:0 are used, sign-extended to 32 bits, and bits 31:8 are ignored.
- R5: The sum wraps modulo 2^32.
- R6: In absolute mode (0) the result is the full 32-bit `in_disp`. The base, the index, the scale code and `in_disp_wide` are ignored.
- R7: Size codes are 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, and 11 = 4 bytes. `out_misaligned` is 1 when (offset & (bytes-1)) != 0. A 1-byte access is never misaligned.
- R8: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1. After that edge `out_valid` is 1 and carries its result. `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_offset` and `out_misaligned` hold steady and `in_ready` is 0.
- R10: Mode code 7 behaves exactly like mode 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_mode | input | 3 | Addressing-mode code |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_scale | input | 2 | Index scale code |
| in_disp | input | 32 | Displacement |
| in_disp_wide | input | 1 | 1 = 32-bit displacement, 0 = 8-bit sign-extended |
| in_size | input | 2 | Access size code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_offset | output | 32 | Effective offset |
| out_misaligned | output | 1 | Offset is not naturally aligned for the size |

## Verification
The bench targets several corner cases.

- **Short negative displacement.** A design that zero-extends instead of sign-extending would land 256 bytes too high.
- **Short displacement with junk in its upper bits.** A leak of those bits would corrupt the offset.
- **Sum that carries past bit 31.** A non-wrapping adder would give a wrong offset.
- **Scale code in an unscaled mode.** A wrong mode decode would multiply the index when it should not.
- **Absolute mode with nonzero base and index, and a cleared wide flag.** A design that did not ignore them would add those operands or truncate the address.
- **Size code 11, and odd offsets with byte size.** Without these, the alignment flag could be off in both directions.
- **Backpressure.** This shows whether a held result is overwritten or a request is dropped.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int ADDR_W       = 32;
    localparam int DISP_SHORT_W = 8;
    localparam int SCALE_W      = 2;
    localparam int SCALE_N      = 1 << SCALE_W;
    localparam int SIZE_W       = 2;
    localparam int MODE_W       = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_ABS           = 3'd0,
        AM_BASE          = 3'd1,
        AM_BASE_DISP     = 3'd2,
        AM_BASE_IDX      = 3'd3,
        AM_BASE_IDX_DISP = 3'd4,
        AM_BASE_SIDX     = 3'd5,
        AM_BASE_SIDX_D   = 3'd6,
        AM_ALIAS_SIDX_D  = 3'd7
    } am_mode_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic use_base;
        logic use_index;
        logic use_scale;
        logic use_disp;
        logic force_wide;
    } term_sel_t;

    typedef struct packed {
        logic [ADDR_W-1:0] offset;
        logic              misaligned;
        acc_size_e         size;
    } agu_result_t;

    function automatic term_sel_t decode_mode(am_mode_e m);
        term_sel_t t;
        t = '0;
        case (m)
            AM_ABS:           begin t.use_disp = 1'b1; t.force_wide = 1'b1; end
            AM_BASE:          t.use_base = 1'b1;
            AM_BASE_DISP:     begin t.use_base = 1'b1; t.use_disp = 1'b1; end
            AM_BASE_IDX:      begin t.use_base = 1'b1; t.use_index = 1'b1; end
            AM_BASE_IDX_DISP: begin t.use_base = 1'b1; t.use_index = 1'b1; t.use_disp = 1'b1; end
            AM_BASE_SIDX:     begin t.use_base = 1'b1; t.use_index = 1'b1; t.use_scale = 1'b1; end
            default:          begin t.use_base = 1'b1; t.use_index = 1'b1;
                                    t.use_scale = 1'b1; t.use_disp = 1'b1; end
        endcase
        return t;
    endfunction

    function automatic logic [ADDR_W-1:0] align_mask(acc_size_e s);
        case (s)
            SZ_BYTE: return '0;
            SZ_HALF: return ADDR_W'(1);
            default: return ADDR_W'(3);
        endcase
    endfunction
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
    parameter int ADDR_W  = agu_pkg::ADDR_W,
    parameter int SHORT_W = agu_pkg::DISP_SHORT_W
) (
    input  logic [ADDR_W-1:0] disp_raw,
    input  logic              wide,
    output logic [ADDR_W-1:0] disp_out
);
    localparam int EXT_W = ADDR_W - SHORT_W;

    logic [SHORT_W-1:0] short_part;
    assign short_part = disp_raw[SHORT_W-1:0];

    always_comb begin
        if (wide) disp_out = disp_raw;
        else      disp_out = {{EXT_W{short_part[SHORT_W-1]}}, short_part};
    end
endmodule

// File: rtl/agu_index_scale.sv
module agu_index_scale #(
    parameter int ADDR_W  = agu_pkg::ADDR_W,
    parameter int SCALE_W = agu_pkg::SCALE_W
) (
    input  logic [ADDR_W-1:0]  index,
    input  logic [SCALE_W-1:0] scale_code,
    input  logic               scale_en,
    output logic [ADDR_W-1:0]  scaled
);
    localparam int N = 1 << SCALE_W;

    logic [ADDR_W-1:0] cand [N];

    for (genvar k = 0; k < N; k++) begin : g_shift
        assign cand[k] = index << k;
    end

    assign scaled = scale_en ? cand[scale_code] : index;
endmodule

// File: rtl/agu_offset_sum.sv
module agu_offset_sum
    import agu_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index_term,
    input  logic [ADDR_W-1:0] disp_term,
    input  term_sel_t         sel,
    input  acc_size_e         size,
    output agu_result_t       result
);
    logic [ADDR_W-1:0] b_t, i_t, d_t, sum;

    always_comb begin
        b_t = sel.use_base  ? base       : '0;
        i_t = sel.use_index ? index_term : '0;
        d_t = sel.use_disp  ? disp_term  : '0;
        sum = b_t + i_t + d_t;
        result.offset     = sum;
        result.misaligned = |(sum & align_mask(size));
        result.size       = size;
    end
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage
    import agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  agu_result_t in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output agu_result_t out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_accept_valid_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/agu_offset_gen.sv
module agu_offset_gen
    import agu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [MODE_W-1:0]   in_mode,
    input  logic [ADDR_W-1:0]   in_base,
    input  logic [ADDR_W-1:0]   in_index,
    input  logic [SCALE_W-1:0]  in_scale,
    input  logic [ADDR_W-1:0]   in_disp,
    input  logic                in_disp_wide,
    input  logic [SIZE_W-1:0]   in_size,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ADDR_W-1:0]   out_offset,
    output logic                out_misaligned
);
    term_sel_t         sel;
    logic [ADDR_W-1:0] disp_term, index_term;
    agu_result_t       comb_res, reg_res;

    assign sel = decode_mode(am_mode_e'(in_mode));

    agu_disp_ext u_disp (
        .disp_raw (in_disp),
        .wide     (in_disp_wide || sel.force_wide),
        .disp_out (disp_term)
    );

    agu_index_scale u_scale (
        .index      (in_index),
        .scale_code (in_scale),
        .scale_en   (sel.use_scale),
        .scaled     (index_term)
    );

    agu_offset_sum u_sum (
        .base       (in_base),
        .index_term (index_term),
        .disp_term  (disp_term),
        .sel        (sel),
        .size       (acc_size_e'(in_size)),
        .result     (comb_res)
    );

    agu_out_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (comb_res),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (reg_res)
    );

    assign out_offset     = reg_res.offset;
    assign out_misaligned = reg_res.misaligned;

    p_byte_never_mis_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && reg_res.size == SZ_BYTE) |-> !out_misaligned);

    p_abs_passthrough_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_mode == 3'd0) |=> (out_offset == $past(in_disp)));
endmodule

// File: tb/agu_offset_gen_tb_top.sv
`timescale 1ns/1ps
module agu_offset_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, in_disp_wide, out_valid, out_ready, out_misaligned;
    logic [2:0]  in_mode;
    logic [31:0] in_base, in_index, in_disp, out_offset;
    logic [1:0]  in_scale, in_size;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    agu_offset_gen dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_base(in_base), .in_index(in_index),
        .in_scale(in_scale), .in_disp(in_disp), .in_disp_wide(in_disp_wide),
        .in_size(in_size), .out_valid(out_valid), .out_ready(out_ready),
        .out_offset(out_offset), .out_misaligned(out_misaligned)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [31:0] base;
        logic [31:0] idx;
        logic [1:0]  scale;
        logic [31:0] disp;
        logic        wide;
        logic [1:0]  size;
        logic [31:0] exp_off;
        logic        exp_mis;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R6: absolute ignores base, index, scale and a cleared wide flag
        '{3'd0, 32'h1111_1111, 32'h2222_2222, 2'd3, 32'h0000_10F0, 1'b0, 2'd2, 32'h0000_10F0, 1'b0},
        // R2 base only, R7 odd halfword
        '{3'd1, 32'h0000_2003, 32'h0000_0005, 2'd1, 32'h0000_0040, 1'b1, 2'd1, 32'h0000_2003, 1'b1},
        // R4 negative short displacement
        '{3'd2, 32'h0000_1000, 32'h0000_0000, 2'd0, 32'h0000_00FC, 1'b0, 2'd2, 32'h0000_0FFC, 1'b0},
        // R4 upper bits of a short displacement ignored
        '{3'd2, 32'h0000_1000, 32'h0000_0000, 2'd0, 32'hABCD_0010, 1'b0, 2'd2, 32'h0000_1010, 1'b0},
        // R3 scale ignored in mode 3, displacement ignored
        '{3'd3, 32'h0000_0100, 32'h0000_0020, 2'd3, 32'h0000_0055, 1'b1, 2'd0, 32'h0000_0120, 1'b0},
        // R3 mode 4 unscaled, positive short displacement
        '{3'd4, 32'h0000_0100, 32'h0000_0020, 2'd2, 32'h0000_007F, 1'b0, 2'd1, 32'h0000_019F, 1'b1},
        // R3 scale x4
        '{3'd5, 32'h0000_1000, 32'h0000_0003, 2'd2, 32'h0000_0011, 1'b1, 2'd2, 32'h0000_100C, 1'b0},
        // R3 scale x8 with -128 displacement
        '{3'd6, 32'h0000_1000, 32'h0000_0003, 2'd3, 32'h0000_0080, 1'b0, 2'd2, 32'h0000_0F98, 1'b0},
        // R5 wrap past 2^32
        '{3'd6, 32'hFFFF_FFF0, 32'h0000_0010, 2'd0, 32'h0000_0002, 1'b1, 2'd2, 32'h0000_0002, 1'b1},
        // R10 mode 7 as mode 6, R7 size code 11 is 4 bytes
        '{3'd7, 32'h0000_0010, 32'h0000_0001, 2'd1, 32'h0000_0005, 1'b1, 2'd3, 32'h0000_0017, 1'b1},
        // R3 scale x1 in scaled mode
        '{3'd5, 32'h0000_0010, 32'h0000_0008, 2'd0, 32'h0000_0000, 1'b1, 2'd2, 32'h0000_0018, 1'b0},
        // R7 byte access at odd offset is aligned
        '{3'd1, 32'h0000_0007, 32'h0000_0000, 2'd0, 32'h0000_0000, 1'b1, 2'd0, 32'h0000_0007, 1'b0}
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic [31:0] b, input logic [31:0] ix,
                         input logic [1:0] sc, input logic [31:0] d, input logic w, input logic [1:0] sz);
        in_mode = m; in_base = b; in_index = ix; in_scale = sc;
        in_disp = d; in_disp_wide = w; in_size = sz; in_valid = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        in_mode = '0; in_base = '0; in_index = '0; in_scale = '0;
        in_disp = '0; in_disp_wide = 1'b0; in_size = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].mode, VECS[i].base, VECS[i].idx, VECS[i].scale,
                  VECS[i].disp, VECS[i].wide, VECS[i].size);
            @(negedge clk);
            check(out_valid == 1'b1, "R8 out_valid after accept", 32'(out_valid), 32'd1);
            check(out_offset == VECS[i].exp_off, "R2 offset", out_offset, VECS[i].exp_off);
            check(out_misaligned == VECS[i].exp_mis, "R7 misaligned", 32'(out_misaligned), 32'(VECS[i].exp_mis));
            in_valid = 1'b0;
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid drops when idle", 32'(out_valid), 32'd0);

        // R9 backpressure
        out_ready = 1'b0;
        drive(3'd1, 32'h0000_0100, 32'h0, 2'd0, 32'h0, 1'b1, 2'd0);
        @(negedge clk);
        check(out_offset == 32'h100, "R9 first result", out_offset, 32'h100);
        drive(3'd1, 32'h0000_0204, 32'h0, 2'd0, 32'h0, 1'b1, 2'd2);
        check(in_ready == 1'b0, "R9 in_ready low while stalled", 32'(in_ready), 32'd0);
        repeat (3) @(negedge clk);
        check(out_offset == 32'h100, "R9 offset held", out_offset, 32'h100);
        check(out_valid == 1'b1, "R9 valid held", 32'(out_valid), 32'd1);
        out_ready = 1'b1;
        #0;
        check(in_ready == 1'b1, "R8 in_ready with out_ready", 32'(in_ready), 32'd1);
        @(negedge clk);
        check(out_offset == 32'h204, "R9 second result after release", out_offset, 32'h204);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 drained", 32'(out_valid), 32'd0);

        // R1 reset in mid-stream
        drive(3'd1, 32'h0000_0040, 32'h0, 2'd0, 32'h0, 1'b1, 2'd0);
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R1 reset clears valid", 32'(out_valid), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule